// File: doc/BRIEF.md
# Sentinel-Terminated Word Serializer

This block turns a parallel word into a serial bit stream and uses no bit counter to do it. The shift register is one bit wider than the word. Each time a word is loaded, the spare top position is set to 1 as a marker. The register shifts toward bit 0 and fills with 0 from the top, so the bits behind the data become zero as they empty. The word is finished when only the marker is left at the output end, that is, when the upper bits are all zero and bit 0 is 1. That pattern is the only thing the control logic inspects.

The word side is a valid/ready handshake. The serial side gives one data bit and a strobe on each enabled clock, least significant bit first. When a word is waiting as the previous one finishes, its bit 0 goes out in the same cycle it is accepted, so consecutive words leave with no gap. The control is a three-phase machine decoded from the register:
- PH_SHIFT: data bits remain in the register.
- PH_RELOAD: only the marker is left and a word is offered.
- PH_IDLE: only the marker is left and nothing is offered.

The transitions are:
- PH_SHIFT to PH_IDLE or PH_RELOAD, when the last data bit shifts out.
- PH_RELOAD to PH_SHIFT, on a load.
- PH_IDLE to PH_RELOAD, when in_valid rises.

The width parameter must be at least 2.

Top module: `sentinel_serializer`

## Requirements
- R1: After synchronous reset the block is idle: in_ready is 1 and ser_valid is 0 until a word is accepted.
- R2: in_ready is 1 exactly when every bit of the last accepted word has been emitted, and 0 while any bit remains.
- R3: A word is accepted only on a cycle with in_valid and in_ready both 1. An in_valid offered while in_ready is 0 changes neither the emitted bits nor their order.
- R4: An accepted word of DATA_W bits leaves on ser_data least significant bit first, one bit per cycle with shift_en high. ser_valid is 1 only on such cycles.
- R5: With shift_en low, ser_valid is 0 and the position within the word does not advance.
- R6: On an accepting cycle with shift_en high, ser_valid is 1 and ser_data equals in_data bit 0 in that same cycle. The remaining DATA_W-1 bits follow, so back-to-back words leave without a gap.
- R7: On an accepting cycle with shift_en low, nothing is emitted, and bit 0 leaves on the next cycle with shift_en high.
- R8: While in_ready is 1 and in_valid is 0, ser_valid is 0. The marker bit is never emitted as data, so each word yields exactly DATA_W strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Parallel word offered |
| in_data | input | DATA_W | Parallel word |
| in_ready | output | 1 | Block can take a word this cycle |
| shift_en | input | 1 | Advance one bit this cycle |
| ser_data | output | 1 | Serial data bit |
| ser_valid | output | 1 | ser_data carries a real bit this cycle |

## Verification
Loading a new word and emitting its first bit can happen in the same cycle. This occurs when in_valid meets in_ready with shift_en high. The bench provokes it in every word of its always-enabled sweep, and also whenever a pseudo-random enable pattern happens to be high at the moment of reload. Each cycle is judged against a remaining-bit count kept in the bench: that cycle must carry in_data bit 0, and the next word's bits must follow with no idle strobe in between.

// File: rtl/sentinel_ser_pkg.sv
package sentinel_ser_pkg;
    typedef enum logic [1:0] {
        PH_SHIFT  = 2'd0,
        PH_IDLE   = 2'd1,
        PH_RELOAD = 2'd2
    } phase_e;
endpackage

// File: rtl/sentinel_detect.sv
// Flags the marker-only pattern: upper bits clear, marker at the output end.
module sentinel_detect #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W:0] sr,
    output logic            at_last
);
    logic [DATA_W-1:0] upper_or;

    genvar g;
    generate
        for (g = 0; g < DATA_W; g++) begin : g_or
            if (g == 0) begin : g_first
                assign upper_or[g] = sr[g+1];
            end else begin : g_rest
                assign upper_or[g] = upper_or[g-1] | sr[g+1];
            end
        end
    endgenerate

    assign at_last = !upper_or[DATA_W-1] && sr[0];
endmodule

// File: rtl/sentinel_shreg.sv
// Shift register one bit wider than the word, with the marker in the top bit and zero fill.
module sentinel_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W:0]   sr
);
    localparam int SR_W = DATA_W + 1;
    localparam logic [SR_W-1:0] MARK_ONLY = {{DATA_W{1'b0}}, 1'b1};

    logic [SR_W-1:0] sr_next;

    always_comb begin
        unique case ({load, shift})
            2'b11:   sr_next = {2'b01, in_data[DATA_W-1:1]};
            2'b10:   sr_next = {1'b1, in_data};
            2'b01:   sr_next = {1'b0, sr[DATA_W:1]};
            default: sr_next = sr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sr <= MARK_ONLY;
        else     sr <= sr_next;
    end

    // R8
    sr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        sr != '0);
endmodule

// File: rtl/sentinel_serializer.sv
module sentinel_serializer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              shift_en,
    output logic              ser_data,
    output logic              ser_valid
);
    import sentinel_ser_pkg::*;

    logic [DATA_W:0] sr;
    logic            at_last;
    logic            do_load;
    logic            do_shift;
    phase_e          phase;

    sentinel_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk     (clk),
        .rst     (rst),
        .load    (do_load),
        .shift   (do_shift),
        .in_data (in_data),
        .sr      (sr)
    );

    sentinel_detect #(.DATA_W(DATA_W)) u_detect (
        .sr      (sr),
        .at_last (at_last)
    );

    // Phase decode from the register state
    always_comb begin
        if (!at_last)      phase = PH_SHIFT;
        else if (in_valid) phase = PH_RELOAD;
        else               phase = PH_IDLE;
    end

    // Outputs and register controls
    always_comb begin
        in_ready  = at_last;
        do_load   = 1'b0;
        do_shift  = 1'b0;
        ser_valid = 1'b0;
        ser_data  = 1'b0;
        unique case (phase)
            PH_SHIFT: begin
                do_shift  = shift_en;
                ser_valid = shift_en;
                ser_data  = sr[0];
            end
            PH_RELOAD: begin
                do_load   = 1'b1;
                do_shift  = shift_en;
                ser_valid = shift_en;
                ser_data  = in_data[0];
            end
            default: begin
            end
        endcase
    end

    // R1
    reset_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> in_ready);
    // R4
    strobe_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        ser_valid |-> shift_en);
    // R5
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !in_ready) |=> !in_ready);
    // R6
    first_bit_now_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && shift_en) |-> (ser_valid && ser_data == in_data[0]));
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |-> !ser_valid);
endmodule

// File: tb/sentinel_serializer_test.sv
module sentinel_serializer_test;
    localparam int DATA_W = 4;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              shift_en = 1'b0;
    logic              in_ready;
    logic              ser_data;
    logic              ser_valid;

    int n_run = 0;
    int n_fail = 0;
    int rem = 0;
    int cyc = 0;
    logic [DATA_W-1:0] cur_word = '0;
    logic [15:0] lfsr = 16'hACE1;

    sentinel_serializer #(.DATA_W(DATA_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .shift_en  (shift_en),
        .ser_data  (ser_data),
        .ser_valid (ser_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [DATA_W-1:0] d, input logic en);
        logic exp_valid;
        logic exp_bit;
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        shift_en = en;
        #1;
        cyc++;
        check((v && rem > 0) ? "R3" : "R2", in_ready, rem == 0);
        exp_valid = en && (rem > 0 || v);
        if (!en)
            check("R5", ser_valid, 1'b0);
        else if (rem == 0 && !v)
            check("R8", ser_valid, 1'b0);
        else
            check("R4", ser_valid, exp_valid);
        if (exp_valid) begin
            if (rem == 0) begin
                exp_bit = d[0];
                check("R6", ser_data, exp_bit);
            end else begin
                exp_bit = cur_word[DATA_W - rem];
                check(rem == DATA_W ? "R7" : "R4", ser_data, exp_bit);
            end
        end
        if (rem == 0 && v) begin
            cur_word = d;
            rem = en ? DATA_W - 1 : DATA_W;
        end else if (rem > 0 && en) begin
            rem--;
        end
    endtask

    function automatic logic en_pat(input int mode);
        if (mode == 0) return 1'b1;
        if (mode == 1) return cyc[0];
        return lfsr[0] | lfsr[3];
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle after reset, no strobe while nothing is offered
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            shift_en = 1'b1;
            in_valid = 1'b0;
            #1;
            check("R1", in_ready, 1'b1);
            check("R1", ser_valid, 1'b0);
        end
        for (int mode = 0; mode < 3; mode++) begin
            for (int w = 0; w < (1 << DATA_W); w++) begin
                while (rem != 0)
                    step(mode == 1, ~w[DATA_W-1:0], en_pat(mode));
                step(1'b1, w[DATA_W-1:0], en_pat(mode));
                if (mode == 2 && (w % 3) == 0)
                    step(1'b0, '0, 1'b1);
            end
        end
        // accept with shift_en low, then first bit later (R7)
        while (rem != 0) step(1'b0, '0, 1'b1);
        step(1'b1, 4'b1001, 1'b0);
        step(1'b0, '0, 1'b0);
        for (int k = 0; k < DATA_W + 2; k++) step(1'b0, '0, 1'b1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule